// File: doc/BRIEF.md
# Adaptive Probability Table Updater

This block refreshes a stored cumulative probability table after a symbol has been decoded with it. It receives the table as it was used (up to fifteen 16-bit entries), the table's adaptation counter, the decoded symbol index and the alphabet size. One clock later it returns the refreshed table and counter, which the surrounding decoder writes back to its table store. Entries at or above the decoded symbol move toward 32768. Entries below it move toward zero. The size of each step is set by a rate that grows with the counter and with the alphabet size. Early updates therefore move the table quickly, and later ones settle it.

A second mode serves two-symbol (boolean) contexts. There, entry 0 holds the single probability and the counter rides alongside it as a pair. That mode uses its own rate rule and its own biased update, driven by the decoded bit. A global enable turns adaptation off. When it is clear, the table and counter come back exactly as they went in.

Top module: `cdfu_adapt`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `out_valid`, `cdf_out` and `count_out` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low. The results of a request appear with that same one-cycle latency.
- R3: Multi-symbol mode (`bool_mode`=0, `adapt_en`=1): entry i, held at bits [16i+15:16i], with sym <= i < nsym-1, becomes c + ((32768 - c) >>> rate). The arithmetic is signed, and the result is truncated to 16 bits.
- R4: Multi-symbol mode: entry i with i < sym and i < nsym-1 becomes c - ((c + 1) >> rate), truncated to 16 bits.
- R5: The multi-symbol rate is 4 + (count_in >> 4), plus 1 when nsym > 2. With nsym = 2, the single updated entry uses 4 + (count_in >> 4).
- R6: Multi-symbol mode: entries with index i >= nsym-1 leave the block unchanged.
- R7: When adaptation is enabled, in either mode, `count_out` is count_in + 1 while count_in < 32 and stays at 32 once it has reached 32. count_in is at most 32.
- R8: With `adapt_en`=0, `cdf_out` equals `cdf_in` and `count_out` equals `count_in`.
- R9: Boolean mode (`bool_mode`=1): with bit b and rate = 4 + (count_in >> 4), entry 0 first becomes c = c0 - b. It then becomes c - ((c - 32769*b) >>> rate), computed in 17-bit signed arithmetic and truncated to 16 bits.
- R10: Boolean mode: entries 1 to 14 leave the block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Update request this cycle |
| adapt_en | input | 1 | Adaptation enable; when low the result is a copy of the inputs |
| bool_mode | input | 1 | 1 selects the two-symbol update on entry 0 |
| bool_bit | input | 1 | Decoded bit in boolean mode |
| nsym | input | 5 | Alphabet size, 2 to 16 (multi-symbol mode) |
| sym | input | 4 | Decoded symbol index, below nsym |
| cdf_in | input | 240 | Current table; entry i at bits [16i+15:16i] |
| count_in | input | 6 | Current adaptation counter, 0 to 32 |
| out_valid | output | 1 | Result valid |
| cdf_out | output | 240 | Updated table, same layout as cdf_in |
| count_out | output | 6 | Updated counter |

## Verification
The hardest situations to reach are the arithmetic edges of the rate. These are entries above 32768 that step downward through a negative arithmetic shift, boolean updates with the probability at 0 and the bit set, and counters just below and at each rate boundary (15, 16, 31, 32). Random tables almost never land on them. The stimulus therefore opens with a directed sweep that crosses these values with nsym of 2, 3 and 16 and with the symbol at both ends of the alphabet. Long random runs follow, with mixed modes, idle gaps and extreme entry values salted in.

// File: rtl/cdfu_pkg.sv
package cdfu_pkg;

    localparam int CDF_W    = 16;
    localparam int MAX_ENT  = 15;
    localparam int CNT_W    = 6;
    localparam int CNT_SAT  = 32;
    localparam int SYM_W    = 4;
    localparam int NSYM_W   = 5;
    localparam int RATE_W   = 3;
    localparam int RATE_MIN = 4;
    localparam int WIDE_W   = CDF_W + 1;
    localparam int TBL_W    = CDF_W * MAX_ENT;
    localparam int HALF     = 1 << (CDF_W - 1);

    typedef logic [CDF_W-1:0]         prob_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic [RATE_W-1:0]        rate_t;
    typedef logic [CNT_W-1:0]         cnt_t;

    typedef enum logic {
        MODE_MULTI = 1'b0,
        MODE_BOOL  = 1'b1
    } upd_mode_e;

    typedef struct packed {
        logic                      vld;
        prob_t [MAX_ENT-1:0]       ent;
        cnt_t                      cnt;
    } upd_res_t;

    // Step size shift for the current request.
    function automatic rate_t calc_rate(cnt_t cnt, logic [NSYM_W-1:0] ns, upd_mode_e mode);
        rate_t r;
        r = rate_t'(RATE_MIN) + rate_t'(cnt >> 4);
        if (mode == MODE_MULTI && ns > NSYM_W'(2))
            r = r + rate_t'(1);
        return r;
    endfunction

    function automatic cnt_t next_count(cnt_t cnt);
        return (cnt < cnt_t'(CNT_SAT)) ? cnt + cnt_t'(1) : cnt;
    endfunction

endpackage

// File: rtl/cdfu_lane.sv
module cdfu_lane
    import cdfu_pkg::*;
#(
    parameter int IDX = 0
) (
    input  prob_t               cur,
    input  logic [SYM_W-1:0]    sym,
    input  logic [NSYM_W-1:0]   nsym,
    input  rate_t               rate,
    input  logic                wr_en,
    output prob_t               nxt
);
    localparam logic [SYM_W-1:0]  MY_IDX  = SYM_W'(IDX);
    localparam logic [NSYM_W-1:0] MY_NEXT = NSYM_W'(IDX + 1);

    wide_t cur_w, diff_up, step_up, sum_up;
    logic [WIDE_W-1:0] inc_dn, step_dn, sum_dn;
    logic in_range, go_up;

    always_comb begin
        cur_w    = wide_t'({1'b0, cur});
        diff_up  = wide_t'(HALF) - cur_w;
        step_up  = diff_up >>> rate;
        sum_up   = cur_w + step_up;
        inc_dn   = {1'b0, cur} + WIDE_W'(1);
        step_dn  = inc_dn >> rate;
        sum_dn   = {1'b0, cur} - step_dn;
        in_range = MY_NEXT < nsym;
        go_up    = MY_IDX >= sym;
        if (wr_en && in_range)
            nxt = go_up ? prob_t'(sum_up) : prob_t'(sum_dn);
        else
            nxt = cur;
    end
endmodule

// File: rtl/cdfu_bool.sv
module cdfu_bool
    import cdfu_pkg::*;
(
    input  prob_t  cur,
    input  logic   bit_val,
    input  rate_t  rate,
    input  logic   wr_en,
    output prob_t  nxt
);
    wide_t base, biased, step, res;

    always_comb begin
        base   = wide_t'({1'b0, cur}) - wide_t'({{(WIDE_W-1){1'b0}}, bit_val});
        biased = bit_val ? base - wide_t'(HALF + 1) : base;
        step   = biased >>> rate;
        res    = base - step;
        nxt    = wr_en ? prob_t'(res) : cur;
    end
endmodule

// File: rtl/cdfu_adapt.sv
module cdfu_adapt
    import cdfu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 adapt_en,
    input  logic                 bool_mode,
    input  logic                 bool_bit,
    input  logic [NSYM_W-1:0]    nsym,
    input  logic [SYM_W-1:0]     sym,
    input  logic [TBL_W-1:0]     cdf_in,
    input  logic [CNT_W-1:0]     count_in,
    output logic                 out_valid,
    output logic [TBL_W-1:0]     cdf_out,
    output logic [CNT_W-1:0]     count_out
);
    upd_mode_e mode;
    rate_t     rate;
    logic      multi_wr, bool_wr;
    prob_t [MAX_ENT-1:0] cur_ent, lane_nxt, sel_nxt;
    prob_t     bool_nxt;
    upd_res_t  res_d, res_q;

    assign mode     = bool_mode ? MODE_BOOL : MODE_MULTI;
    assign rate     = calc_rate(count_in, nsym, mode);
    assign multi_wr = adapt_en && (mode == MODE_MULTI);
    assign bool_wr  = adapt_en && (mode == MODE_BOOL);

    for (genvar g = 0; g < MAX_ENT; g++) begin : g_lane
        assign cur_ent[g] = cdf_in[g*CDF_W +: CDF_W];
        cdfu_lane #(.IDX(g)) lane_i (
            .cur   (cur_ent[g]),
            .sym   (sym),
            .nsym  (nsym),
            .rate  (rate),
            .wr_en (multi_wr),
            .nxt   (lane_nxt[g])
        );
        if (g == 0) begin : g_sel0
            assign sel_nxt[g] = bool_wr ? bool_nxt : lane_nxt[g];
        end else begin : g_seln
            assign sel_nxt[g] = lane_nxt[g];
        end
    end

    cdfu_bool bool_i (
        .cur     (cur_ent[0]),
        .bit_val (bool_bit),
        .rate    (rate),
        .wr_en   (bool_wr),
        .nxt     (bool_nxt)
    );

    always_comb begin
        res_d.vld = in_valid;
        res_d.ent = sel_nxt;
        res_d.cnt = adapt_en ? next_count(count_in) : count_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= res_d.vld;
            if (in_valid) begin
                res_q.ent <= res_d.ent;
                res_q.cnt <= res_d.cnt;
            end
        end
    end

    assign out_valid = res_q.vld;
    assign cdf_out   = res_q.ent;
    assign count_out = res_q.cnt;
endmodule

// File: rtl/cdfu_adapt_chk.sv
module cdfu_adapt_chk
    import cdfu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 adapt_en,
    input  logic                 bool_mode,
    input  logic [NSYM_W-1:0]    nsym,
    input  logic [TBL_W-1:0]     cdf_in,
    input  logic [CNT_W-1:0]     count_in,
    input  logic                 out_valid,
    input  logic [TBL_W-1:0]     cdf_out,
    input  logic [CNT_W-1:0]     count_out
);
    localparam int TOP = MAX_ENT - 1;

    a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> count_out <= CNT_W'(CNT_SAT));

    a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
        (in_valid && adapt_en && count_in < CNT_W'(CNT_SAT))
        |=> count_out == $past(count_in) + CNT_W'(1));

    a_r8_pass_through: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !adapt_en) |=> (cdf_out == $past(cdf_in) && count_out == $past(count_in)));

    a_r6_top_untouched: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bool_mode && nsym < NSYM_W'(MAX_ENT + 1))
        |=> cdf_out[TOP*CDF_W +: CDF_W] == $past(cdf_in[TOP*CDF_W +: CDF_W]));

    a_r10_bool_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bool_mode) |=> cdf_out[TBL_W-1:CDF_W] == $past(cdf_in[TBL_W-1:CDF_W]));
endmodule

bind cdfu_adapt cdfu_adapt_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .adapt_en  (adapt_en),
    .bool_mode (bool_mode),
    .nsym      (nsym),
    .cdf_in    (cdf_in),
    .count_in  (count_in),
    .out_valid (out_valid),
    .cdf_out   (cdf_out),
    .count_out (count_out)
);

// File: tb/cdfu_adapt_tb.sv
module cdfu_adapt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 15;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, adapt_en = 1'b0, bool_mode = 1'b0, bool_bit = 1'b0;
    logic [4:0] nsym = 5'd2;
    logic [3:0] sym = 4'd0;
    logic [239:0] cdf_in = '0;
    logic [5:0] count_in = '0;
    logic out_valid;
    logic [239:0] cdf_out;
    logic [5:0] count_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit pend = 1'b0;

    bit           q_en[$];
    bit           q_bm[$];
    bit           q_bb[$];
    int           q_ns[$];
    int           q_sy[$];
    logic [239:0] q_cdf[$];
    int           q_cn[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cdfu_adapt dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .adapt_en(adapt_en),
        .bool_mode(bool_mode), .bool_bit(bool_bit), .nsym(nsym), .sym(sym),
        .cdf_in(cdf_in), .count_in(count_in), .out_valid(out_valid),
        .cdf_out(cdf_out), .count_out(count_out)
    );

    // Behavioural reference for one entry, integer arithmetic.
    function automatic int ref_entry(bit en, bit bm, bit bb, int ns, int sy,
                                     int c0, int cn, int i);
        int rate;
        int c;
        int d;
        c = c0;
        if (!en) return c0;
        if (bm) begin
            if (i != 0) return c0;
            rate = 4 + cn / 16;
            c = c0 - (bb ? 1 : 0);
            d = c - (bb ? 32769 : 0);
            c = c - (d >>> rate);
        end else begin
            if (i >= ns - 1) return c0;
            rate = 4 + cn / 16 + ((ns > 2) ? 1 : 0);
            if (i >= sy) c = c0 + ((32768 - c0) >>> rate);
            else         c = c0 - ((c0 + 1) >>> rate);
        end
        return c & 16'hFFFF;
    endfunction

    function automatic string field_tag(bit en, bit bm, int ns, int sy, int i);
        if (!en) return "R8";
        if (bm) return (i == 0) ? "R9" : "R10";
        if (i >= ns - 1) return "R6";
        if (ns == 2) return "R5";
        return (i >= sy) ? "R3" : "R4";
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out();
        bit en, bm, bb;
        int ns, sy, cn, ecn;
        logic [239:0] ci;
        if (!pend) begin
            check("R2", int'(out_valid), 0);
            return;
        end
        en = q_en.pop_front(); bm = q_bm.pop_front(); bb = q_bb.pop_front();
        ns = q_ns.pop_front(); sy = q_sy.pop_front();
        ci = q_cdf.pop_front(); cn = q_cn.pop_front();
        check("R2", int'(out_valid), 1);
        for (int i = 0; i < NE; i++)
            check(field_tag(en, bm, ns, sy, i), int'(cdf_out[i*16 +: 16]),
                  ref_entry(en, bm, bb, ns, sy, int'(ci[i*16 +: 16]), cn, i));
        ecn = en ? ((cn < 32) ? cn + 1 : cn) : cn;
        check(en ? "R7" : "R8", int'(count_out), ecn);
    endtask

    task automatic step(bit vld, bit en, bit bm, bit bb, int ns, int sy,
                        logic [239:0] ci, int cn);
        @(negedge clk);
        check_out();
        in_valid  = vld;
        adapt_en  = en;
        bool_mode = bm;
        bool_bit  = bb;
        nsym      = 5'(ns);
        sym       = 4'(sy);
        cdf_in    = ci;
        count_in  = 6'(cn);
        pend      = vld;
        if (vld) begin
            q_en.push_back(en); q_bm.push_back(bm); q_bb.push_back(bb);
            q_ns.push_back(ns); q_sy.push_back(sy);
            q_cdf.push_back(ci); q_cn.push_back(cn);
        end
    endtask

    function automatic logic [239:0] fill_tbl(int v);
        logic [239:0] t;
        for (int i = 0; i < NE; i++) t[i*16 +: 16] = 16'(v + i * 1111);
        return t;
    endfunction

    function automatic logic [239:0] rand_tbl();
        logic [239:0] t;
        for (int i = 0; i < NE; i++) begin
            case ($urandom % 6)
                0: t[i*16 +: 16] = 16'h0000;
                1: t[i*16 +: 16] = 16'hFFFF;
                2: t[i*16 +: 16] = 16'h8000;
                default: t[i*16 +: 16] = 16'($urandom);
            endcase
        end
        return t;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cnts[5];
        int nss[4];
        cnts = '{0, 15, 16, 31, 32};
        nss  = '{2, 3, 8, 16};
        repeat (3) begin
            @(negedge clk);
            check("R1", int'(out_valid), 0);
            check("R1", int'(cdf_out != '0), 0);
            check("R1", int'(count_out), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        check("R1", int'(out_valid), 0);
        check("R1", int'(count_out), 0);

        // Directed sweep over rate boundaries, alphabet sizes and symbol ends.
        foreach (cnts[c]) begin
            foreach (nss[n]) begin
                step(1, 1, 0, 0, nss[n], 0, fill_tbl(40000), cnts[c]);
                step(1, 1, 0, 0, nss[n], nss[n]-1, fill_tbl(100), cnts[c]);
                step(1, 1, 0, 0, nss[n], nss[n]/2, {15{16'hFFFF}}, cnts[c]);
                step(1, 1, 0, 0, nss[n], 1, {15{16'h0000}}, cnts[c]);
            end
            step(1, 1, 1, 0, 2, 0, fill_tbl(20000), cnts[c]);
            step(1, 1, 1, 1, 2, 0, fill_tbl(20000), cnts[c]);
            step(1, 1, 1, 1, 2, 0, {15{16'h0000}}, cnts[c]);
            step(1, 1, 1, 0, 2, 0, {15{16'hFFFF}}, cnts[c]);
            step(1, 0, 0, 0, 16, 3, fill_tbl(7), cnts[c]);
            step(1, 0, 1, 1, 2, 0, fill_tbl(9), cnts[c]);
            step(0, 1, 0, 0, 4, 0, fill_tbl(5), cnts[c]);
        end

        // Random traffic with gaps and mixed modes.
        for (int k = 0; k < 4000; k++) begin
            int ns;
            ns = 2 + int'($urandom % 15);
            step(($urandom % 5) != 0, ($urandom % 6) != 0, ($urandom % 4) == 0,
                 $urandom % 2, ns, int'($urandom % ns), rand_tbl(), int'($urandom % 33));
        end
        step(0, 0, 0, 0, 2, 0, '0, 0);
        step(0, 0, 0, 0, 2, 0, '0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule